// File: doc/BRIEF.md
# Masked Clear-on-Read Interrupt Aggregator

This block gathers single-cycle event pulses from internal resources into a small bank of interrupt status registers. Each event is gated by a per-bit enable held in a mask register. Only enabled events are recorded. A recorded bit stays set until the host reads the register that holds it. The block drives an active-low interrupt line that is low whenever any status bit in any register is set.

The host writes mask registers through a simple write strobe with an index. It reads status registers with a read strobe and an index. Each read returns the register's contents one cycle later and clears that register at the same edge. An event that arrives in the cycle of the read is kept, so it is not lost. The read response has no back-pressure: a request is accepted in every cycle, and the host must take `rd_valid`/`rd_data` in the cycle they are presented. The status and mask interfaces are plain control pins.

Top module: `irq_aggregator`

## Requirements
- R1: There are NREG=4 status registers of W=8 bits each. The event input bit `evt_i[r*8+b]` maps to bit b of status register r. Register r is selected by index value r on `rd_idx` and `mask_idx`.
- R2: An event pulse sets its status bit at the next clock edge only if the matching mask bit is 1 in that cycle. An event with a mask bit of 0 leaves no trace.
- R3: `irq_n` is 0 when any status bit of any register is 1, and 1 when all registers are zero. It follows the status registers with no extra register stage.
- R4: A read strobe (`rd_req`=1) with index r clears status register r at that clock edge. The other registers keep their contents.
- R5: An enabled event that arrives in the same cycle as a read of its register is kept. Its bit is set after the clear.
- R6: `rd_valid` is 1 for exactly one cycle, the cycle after `rd_req`. In that cycle `rd_data` holds the register's value from the strobe cycle, before the clear.
- R7: After reset all mask bits and all status bits are 0, `irq_n` is 1 and `rd_valid` is 0. Out of reset every event is therefore ignored.
- R8: A set status bit stays set until its register is read. Clearing the mask bit does not clear the status bit.
- R9: `mask_we`=1 writes `mask_wdata` into mask register `mask_idx`. The new value gates events from the following cycle on. An event in the write cycle uses the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, 8 per register |
| mask_we | input | 1 | Mask write strobe |
| mask_idx | input | 2 | Mask register index |
| mask_wdata | input | 8 | Mask write value |
| rd_req | input | 1 | Status read strobe |
| rd_idx | input | 2 | Status register index to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | 8 | Status value from before the clear |
| irq_n | output | 1 | Active-low interrupt, low while any status bit is set |

## Verification
The bench aims at these cases:
- **Event in the read cycle.** A design that clears after merging the event drops it and leaves `irq_n` high.
- **Mask write in the same cycle as an event.** A bypass of the new mask records or drops the wrong bits.
- **Back-to-back reads of different registers.** These catch clears that spill into neighbouring registers.
- **Mask cleared after a bit is already set.** A design that gates status by the current mask loses the pending bit.

Each of these faults shows up as a `rd_data` or `irq_n` mismatch against the behavioural model, which the bench compares in every cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned NREG_DEF = 4;
  localparam int unsigned REGW_DEF = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask <= '0;
    else if (we) mask <= wdata;
  end

  // R9
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mask == $past(wdata));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  input  logic         clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] gated;

  always_comb gated = evt & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (clr) stat <= gated;
    else          stat <= stat | gated;
  end

  // R2
  only_enabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt & mask)) == '0));

  // R4
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((stat & ~$past(evt & mask)) == '0));

  // R5
  keep_same_cycle_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((stat & $past(evt & mask)) == $past(evt & mask)));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int unsigned NREG = 4,
  parameter int unsigned W    = 8,
  parameter int unsigned IW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic [IW-1:0]   rd_idx,
  input  logic [NREG*W-1:0] stat_flat,
  output logic            rd_valid,
  output logic [W-1:0]    rd_data
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_idx == IW'(r)) sel = stat_flat[r*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= sel;
    end
  end

  // R6
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R6
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NREG = NREG_DEF,
  parameter int unsigned W    = REGW_DEF,
  parameter int unsigned IW   = idx_width(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*W-1:0] evt_i,
  input  logic              mask_we,
  input  logic [IW-1:0]     mask_idx,
  input  logic [W-1:0]      mask_wdata,
  input  logic              rd_req,
  input  logic [IW-1:0]     rd_idx,
  output logic              rd_valid,
  output logic [W-1:0]      rd_data,
  output logic              irq_n
);
  localparam int unsigned TOTAL = NREG * W;

  logic [TOTAL-1:0] stat_flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] mask_q;
    logic         wr_hit;
    logic         rd_hit;

    always_comb begin
      wr_hit = mask_we && (mask_idx == IW'(g));
      rd_hit = rd_req  && (rd_idx   == IW'(g));
    end

    irq_mask_reg #(.W(W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_hit),
      .wdata (mask_wdata),
      .mask  (mask_q)
    );

    irq_status_reg #(.W(W)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_i[g*W +: W]),
      .mask  (mask_q),
      .clr   (rd_hit),
      .stat  (stat_flat[g*W +: W])
    );
  end

  irq_read_port #(.NREG(NREG), .W(W), .IW(IW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_idx    (rd_idx),
    .stat_flat (stat_flat),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_comb irq_n = ~(|stat_flat);

  // R3
  irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|evt_i));

  // R3
  irq_release_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(rd_req));

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (irq_n && !rd_valid));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NR = 4;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR*RW-1:0] evt_i = '0;
  logic          mask_we = 1'b0;
  logic [1:0]    mask_idx = '0;
  logic [RW-1:0] mask_wdata = '0;
  logic          rd_req = 1'b0;
  logic [1:0]    rd_idx = '0;
  logic          rd_valid;
  logic [RW-1:0] rd_data;
  logic          irq_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // behavioural model
  logic [7:0] m_stat [NR];
  logic [7:0] m_mask [NR];
  bit         m_rdv;
  logic [7:0] m_rdd;

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_we(mask_we),
    .mask_idx(mask_idx), .mask_wdata(mask_wdata), .rd_req(rd_req),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic bit any_set();
    for (int r = 0; r < NR; r++) if (m_stat[r] != 0) return 1;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // compare outputs against model (called at negedge)
  task automatic compare();
    chk("R3 irq_n", irq_n, any_set() ? 0 : 1);
    chk("R6 rd_valid", rd_valid, m_rdv);
    if (m_rdv) chk("R6/R4 rd_data", rd_data, m_rdd);
  endtask

  // drive one cycle and advance the model as of the next rising edge
  task automatic step(input logic [31:0] ev, input bit we, input int mi,
                      input logic [7:0] mw, input bit rq, input int ri);
    logic [7:0] g;
    @(negedge clk);
    compare();
    evt_i = ev; mask_we = we; mask_idx = mi[1:0]; mask_wdata = mw;
    rd_req = rq; rd_idx = ri[1:0];
    m_rdv = rq;
    if (rq) m_rdd = m_stat[ri];
    for (int r = 0; r < NR; r++) begin
      g = ev[r*8 +: 8] & m_mask[r];            // R2: old mask gates (R9)
      if (rq && ri == r) m_stat[r] = g;          // R4, R5
      else               m_stat[r] = m_stat[r] | g; // R8
    end
    if (we) m_mask[mi] = mw;                     // R9
    cyc++;
  endtask

  task automatic idle();
    step(32'h0, 0, 0, 8'h0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int r = 0; r < NR; r++) begin m_stat[r] = 0; m_mask[r] = 0; end
    m_rdv = 0; m_rdd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    chk("R7 irq_n at reset", irq_n, 1);
    chk("R7 rd_valid at reset", rd_valid, 0);
    rst_n = 1'b1;

    // R7: events with all masks zero are ignored; reads return 0 (R1)
    step(32'hFFFF_FFFF, 0, 0, 8'h0, 0, 0);
    for (int r = 0; r < NR; r++) step(32'h0, 0, 0, 8'h0, 1, r);
    idle();

    // R9: write masks; event in write cycle uses old mask (zero)
    step(32'h0000_00FF, 1, 0, 8'h0F, 0, 0);
    step(32'h0, 1, 1, 8'hF0, 0, 0);
    step(32'h0, 1, 2, 8'hAA, 0, 0);
    step(32'h0, 1, 3, 8'h81, 0, 0);
    step(32'h0, 0, 0, 8'h0, 1, 0);               // R9 read: expect 0
    // R2: partial mask, R1 bit mapping
    step(32'h8155_F0FF, 0, 0, 8'h0, 0, 0);
    idle();
    // R8: clear mask of reg 1, bit must stay
    step(32'h0, 1, 1, 8'h00, 0, 0);
    idle();
    // R4: read reg 2 only, others stay; back-to-back reads
    step(32'h0, 0, 0, 8'h0, 1, 2);
    step(32'h0, 0, 0, 8'h0, 1, 0);
    step(32'h0, 0, 0, 8'h0, 1, 1);
    idle();
    // R5: event in read cycle of same register survives
    step(32'h8100_0000, 0, 0, 8'h0, 1, 3);
    idle();
    step(32'h0, 0, 0, 8'h0, 1, 3);
    // R3: irq released once last register cleared
    idle();
    step(32'h0, 0, 0, 8'h0, 1, 3);
    idle(); idle();

    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      step($urandom, ($urandom % 8) == 0, $urandom % 4, 8'($urandom),
           ($urandom % 3) == 0, $urandom % 4);
    end
    idle();
    // drain: read everything, expect irq_n high (R3)
    for (int r = 0; r < NR; r++) step(32'h0, 0, 0, 8'h0, 1, r);
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule